// File: doc/BRIEF.md
# Multi-Channel Block Copy Engine

This block moves blocks of bytes between a banked memory space and a fixed peripheral register. It has eight channels. Each channel holds its own settings: the copy direction, how the memory offset steps, a peripheral register address, a memory bank, a 16-bit memory offset and a 16-bit byte count.

Software first writes the settings of one or more channels through a byte-wide configuration port. It then writes a start mask with one bit per channel. The engine runs the started channels one after another. While any started channel remains, it holds the processor off the bus through a halt output.

Every byte takes a read bus cycle followed by a write bus cycle on a simple synchronous master port. A new byte is begun only while vertical blank or forced blank is active.

Top module: `blkdma_ctrl`

## Requirements
- R1: After reset, halt_o is low, bus_req is low, and every configuration register and the start mask read back as zero.
- R2: Configuration address {0, channel[2:0], index[2:0]} selects these channel registers:
  - index 0: control, where bit 0 is the direction and bits 2:1 are the step mode.
  - index 1: peripheral register address.
  - index 2 and index 3: offset low byte and offset high byte.
  - index 4: bank.
  - index 5 and index 6: count low byte and count high byte.
  
  Each register reads back what was written.
- R3: A write to address 0x40 sets the start bits given in the data byte. halt_o is high from the clock edge that takes that write until the last byte of the last started channel has been written.
- R4: When several channels are pending, they run one at a time in ascending channel number. A channel runs all of its bytes before the next channel begins.
- R5: Each byte is one read cycle (bus_we low) followed by one write cycle (bus_we high) that carries the data just read. With direction 0, the engine reads memory and writes the peripheral. With direction 1, it reads the peripheral and writes memory.
- R6: Step mode 00 increments the memory offset after each byte. Step mode 01 decrements it. Step modes 1x leave it unchanged.
- R7: A memory access drives bus_addr = {bank, offset}. The offset wraps modulo 65536, and the bank byte never changes during a transfer.
- R8: A byte count of zero moves 65536 bytes.
- R9: After a channel completes, its offset register reads back the final stepped value, its count reads back zero, and its start bit (start mask read at 0x40) is clear.
- R10: While neither vblank_i nor fblank_i is high, no new byte begins and halt_o stays high. Asserting either input lets the transfer proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration address: bit 6 selects the start mask, otherwise channel and register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| vblank_i | input | 1 | Vertical blank active |
| fblank_i | input | 1 | Forced blank active |
| halt_o | output | 1 | Processor halt while any channel is pending |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_periph | output | 1 | Cycle targets the peripheral register rather than memory |
| bus_addr | output | 24 | {bank, offset} for memory; the peripheral address in bits 7:0 otherwise |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, returned within the read cycle |

## Verification
The bench aims at the places where addressing goes wrong:
- Offset wrap in both directions. A design that carried into the bank, or used a narrow offset, would leave the bank or write to the wrong address.
- The fixed step mode, which must not move the offset.
- The zero count. A design that treated zero as empty would finish at once; one that did not wrap the count would never stop.

The bench starts four channels together and records the peripheral addresses. This catches an arbiter that picks channels out of order or interleaves them.

A run with both blank inputs low catches an engine that ignores the gate. The readback after each transfer catches a design that does not write back the final offset and count, or that leaves the start bit set.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_WR   = 2'd2
  } eng_state_e;

  localparam int OFS_W  = 16;
  localparam int BANK_W = 8;
  localparam int PER_W  = 8;
  localparam int ADDR_W = BANK_W + OFS_W;

  localparam logic [1:0] STEP_INC = 2'b00;
  localparam logic [1:0] STEP_DEC = 2'b01;

  localparam logic [2:0] RIX_CTL   = 3'd0;
  localparam logic [2:0] RIX_PER   = 3'd1;
  localparam logic [2:0] RIX_OFS_L = 3'd2;
  localparam logic [2:0] RIX_OFS_H = 3'd3;
  localparam logic [2:0] RIX_BANK  = 3'd4;
  localparam logic [2:0] RIX_CNT_L = 3'd5;
  localparam logic [2:0] RIX_CNT_H = 3'd6;
endpackage

// File: rtl/blkdma_prio.sv
module blkdma_prio #(
  parameter int N   = 8,
  parameter int IDX = $clog2(N)
) (
  input  logic [N-1:0]   req_i,
  output logic [IDX-1:0] idx_o,
  output logic           any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/blkdma_chan_regs.sv
module blkdma_chan_regs
  import blkdma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        cfg_glb,
  input  logic [CH_W-1:0]             cfg_ch,
  input  logic [2:0]                  cfg_rix,
  input  logic [7:0]                  cfg_wdata,
  output logic [7:0]                  cfg_rdata,
  input  logic                        upd_en,
  input  logic [CH_W-1:0]             upd_ch,
  input  logic [OFS_W-1:0]            upd_ofs,
  input  logic [OFS_W-1:0]            upd_cnt,
  input  logic                        upd_last,
  output logic [NCH-1:0]              dir_o,
  output logic [NCH-1:0][1:0]         step_o,
  output logic [NCH-1:0][PER_W-1:0]   per_o,
  output logic [NCH-1:0][BANK_W-1:0]  bank_o,
  output logic [NCH-1:0][OFS_W-1:0]   ofs_o,
  output logic [NCH-1:0][OFS_W-1:0]   cnt_o,
  output logic [NCH-1:0]              start_o
);
  logic [NCH-1:0] start_n, start_set, start_clr;
  logic           start_en;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit_w, hit_u, en;
    logic [2:0]        ctl_q, ctl_n;
    logic [PER_W-1:0]  per_q, per_n;
    logic [BANK_W-1:0] bank_q, bank_n;
    logic [OFS_W-1:0]  ofs_q, ofs_n, cnt_q, cnt_n;

    assign hit_w = cfg_we && !cfg_glb && (cfg_ch == CH_W'(c));
    assign hit_u = upd_en && (upd_ch == CH_W'(c));
    assign en    = hit_w || hit_u;

    always_comb begin
      ctl_n  = ctl_q;
      per_n  = per_q;
      bank_n = bank_q;
      ofs_n  = ofs_q;
      cnt_n  = cnt_q;
      if (hit_w) begin
        case (cfg_rix)
          RIX_CTL:   ctl_n  = cfg_wdata[2:0];
          RIX_PER:   per_n  = cfg_wdata;
          RIX_OFS_L: ofs_n  = {ofs_q[15:8], cfg_wdata};
          RIX_OFS_H: ofs_n  = {cfg_wdata, ofs_q[7:0]};
          RIX_BANK:  bank_n = cfg_wdata;
          RIX_CNT_L: cnt_n  = {cnt_q[15:8], cfg_wdata};
          RIX_CNT_H: cnt_n  = {cfg_wdata, cnt_q[7:0]};
          default: ;
        endcase
      end
      if (hit_u) begin
        ofs_n = upd_ofs;
        cnt_n = upd_cnt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q  <= '0;
        per_q  <= '0;
        bank_q <= '0;
        ofs_q  <= '0;
        cnt_q  <= '0;
      end else if (en) begin
        ctl_q  <= ctl_n;
        per_q  <= per_n;
        bank_q <= bank_n;
        ofs_q  <= ofs_n;
        cnt_q  <= cnt_n;
      end
    end

    assign dir_o[c]  = ctl_q[0];
    assign step_o[c] = ctl_q[2:1];
    assign per_o[c]  = per_q;
    assign bank_o[c] = bank_q;
    assign ofs_o[c]  = ofs_q;
    assign cnt_o[c]  = cnt_q;
    assign start_clr[c] = hit_u && upd_last;
    assign start_set[c] = cfg_we && cfg_glb && cfg_wdata[c];
  end

  assign start_en = (|start_set) || (|start_clr);
  assign start_n  = (start_o & ~start_clr) | start_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_o <= '0;
    else if (start_en) start_o <= start_n;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_glb) begin
      cfg_rdata = 8'(start_o);
    end else begin
      case (cfg_rix)
        RIX_CTL:   cfg_rdata = {5'd0, step_o[cfg_ch], dir_o[cfg_ch]};
        RIX_PER:   cfg_rdata = per_o[cfg_ch];
        RIX_OFS_L: cfg_rdata = ofs_o[cfg_ch][7:0];
        RIX_OFS_H: cfg_rdata = ofs_o[cfg_ch][15:8];
        RIX_BANK:  cfg_rdata = bank_o[cfg_ch];
        RIX_CNT_L: cfg_rdata = cnt_o[cfg_ch][7:0];
        RIX_CNT_H: cfg_rdata = cnt_o[cfg_ch][15:8];
        default:   cfg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
  import blkdma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank_i,
  input  logic              pend_i,
  input  logic [CH_W-1:0]   gnt_i,
  input  logic              dir_i,
  input  logic [1:0]        step_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [OFS_W-1:0]  cnt_i,
  input  logic [7:0]        rdata_i,
  output logic [CH_W-1:0]   cur_ch_o,
  output logic              req_o,
  output logic              we_o,
  output logic              periph_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              upd_en_o,
  output logic [OFS_W-1:0]  upd_ofs_o,
  output logic [OFS_W-1:0]  upd_cnt_o,
  output logic              upd_last_o
);
  eng_state_e      st_q, st_n;
  logic [CH_W-1:0] ch_q, ch_n;
  logic [7:0]      dat_q, dat_n;
  logic            st_en, ch_en, dat_en;

  assign upd_last_o = (cnt_i == OFS_W'(1));
  assign upd_cnt_o  = cnt_i - OFS_W'(1);

  always_comb begin
    case (step_i)
      STEP_INC: upd_ofs_o = ofs_i + OFS_W'(1);
      STEP_DEC: upd_ofs_o = ofs_i - OFS_W'(1);
      default:  upd_ofs_o = ofs_i;
    endcase
  end

  always_comb begin
    st_n     = st_q;
    ch_n     = ch_q;
    dat_n    = dat_q;
    upd_en_o = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (pend_i && blank_i) begin
          ch_n = gnt_i;
          st_n = ENG_RD;
        end
      end
      ENG_RD: begin
        dat_n = rdata_i;
        st_n  = ENG_WR;
      end
      ENG_WR: begin
        upd_en_o = 1'b1;
        st_n     = (!upd_last_o && blank_i) ? ENG_RD : ENG_IDLE;
      end
      default: st_n = ENG_IDLE;
    endcase
  end

  assign st_en  = (st_n != st_q);
  assign ch_en  = (st_q == ENG_IDLE);
  assign dat_en = (st_q == ENG_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      ch_q  <= '0;
      dat_q <= '0;
    end else begin
      if (st_en)  st_q  <= st_n;
      if (ch_en)  ch_q  <= ch_n;
      if (dat_en) dat_q <= dat_n;
    end
  end

  assign cur_ch_o = ch_q;
  assign req_o    = (st_q != ENG_IDLE);
  assign we_o     = (st_q == ENG_WR);
  assign periph_o = req_o && ((st_q == ENG_RD) ? dir_i : !dir_i);
  assign addr_o   = periph_o ? ADDR_W'(per_i) : {bank_i, ofs_i};
  assign wdata_o  = dat_q;
endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CH_W   = $clog2(NCH),
  parameter int CFG_AW = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              vblank_i,
  input  logic              fblank_i,
  output logic              halt_o,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_periph,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata
);
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [NCH-1:0]             dir_a, start_a;
  logic [NCH-1:0][1:0]        step_a;
  logic [NCH-1:0][PER_W-1:0]  per_a;
  logic [NCH-1:0][BANK_W-1:0] bank_a;
  logic [NCH-1:0][OFS_W-1:0]  ofs_a, cnt_a;
  logic [CH_W-1:0]            gnt, cur_ch;
  logic                       pend, upd_en, upd_last;
  logic [OFS_W-1:0]           upd_ofs, upd_cnt;

  blkdma_chan_regs #(.NCH(NCH), .CH_W(CH_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_i),
    .cfg_we    (cfg_we),
    .cfg_glb   (cfg_addr[CFG_AW-1]),
    .cfg_ch    (cfg_addr[CH_W+2:3]),
    .cfg_rix   (cfg_addr[2:0]),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .upd_en    (upd_en),
    .upd_ch    (cur_ch),
    .upd_ofs   (upd_ofs),
    .upd_cnt   (upd_cnt),
    .upd_last  (upd_last),
    .dir_o     (dir_a),
    .step_o    (step_a),
    .per_o     (per_a),
    .bank_o    (bank_a),
    .ofs_o     (ofs_a),
    .cnt_o     (cnt_a),
    .start_o   (start_a)
  );

  blkdma_prio #(.N(NCH), .IDX(CH_W)) prio_i (
    .req_i (start_a),
    .idx_o (gnt),
    .any_o (pend)
  );

  blkdma_engine #(.NCH(NCH), .CH_W(CH_W)) eng_i (
    .clk        (clk),
    .rst_n      (rst_i),
    .blank_i    (vblank_i || fblank_i),
    .pend_i     (pend),
    .gnt_i      (gnt),
    .dir_i      (dir_a[cur_ch]),
    .step_i     (step_a[cur_ch]),
    .per_i      (per_a[cur_ch]),
    .bank_i     (bank_a[cur_ch]),
    .ofs_i      (ofs_a[cur_ch]),
    .cnt_i      (cnt_a[cur_ch]),
    .rdata_i    (bus_rdata),
    .cur_ch_o   (cur_ch),
    .req_o      (bus_req),
    .we_o       (bus_we),
    .periph_o   (bus_periph),
    .addr_o     (bus_addr),
    .wdata_o    (bus_wdata),
    .upd_en_o   (upd_en),
    .upd_ofs_o  (upd_ofs),
    .upd_cnt_o  (upd_cnt),
    .upd_last_o (upd_last)
  );

  assign halt_o = pend;
endmodule

// File: rtl/blkdma_ctrl_chk.sv
module blkdma_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        vblank_i,
  input logic        fblank_i,
  input logic        halt_o,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_periph,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata
);
  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> $past(bus_req && !bus_we));

  a_r5_copies_read_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_wdata == $past(bus_rdata)));

  a_r5_opposite_sides: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_periph != $past(bus_periph)));

  a_r10_read_needs_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |-> $past(vblank_i || fblank_i));

  a_r3_halt_during_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> halt_o);

  a_r3_halt_drops_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_o) |-> $past(bus_req && bus_we));
endmodule

bind blkdma_ctrl blkdma_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .vblank_i   (vblank_i),
  .fblank_i   (fblank_i),
  .halt_o     (halt_o),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_periph (bus_periph),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata)
);

// File: tb/blkdma_ctrl_tb_top.sv
module blkdma_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        vblank_i = 1'b1;
  logic        fblank_i = 1'b0;
  logic        halt_o, bus_req, bus_we, bus_periph;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  assign bus_rdata = bus_periph ? (bus_addr[7:0] ^ 8'hA5) : mem_val(bus_addr);

  blkdma_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vblank_i(vblank_i),
    .fblank_i(fblank_i), .halt_o(halt_o), .bus_req(bus_req), .bus_we(bus_we),
    .bus_periph(bus_periph), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // bus monitor
  int          n_bytes = 0;
  int          data_err = 0;
  logic [7:0]  exp_b;
  logic [23:0] rd_a;
  logic [23:0] last_m;
  logic [23:0] log_m [64];
  logic [7:0]  log_p [64];
  logic        log_tp [64];

  always @(negedge clk) begin
    if (rst_n && bus_req) begin
      if (!bus_we) begin
        exp_b = bus_periph ? (bus_addr[7:0] ^ 8'hA5) : mem_val(bus_addr);
        rd_a  = bus_addr;
      end else begin
        if (bus_wdata != exp_b) data_err++;
        last_m = bus_periph ? rd_a : bus_addr;
        if (n_bytes < 64) begin
          log_m[n_bytes]  = last_m;
          log_p[n_bytes]  = bus_periph ? bus_addr[7:0] : rd_a[7:0];
          log_tp[n_bytes] = bus_periph;
        end
        n_bytes++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    cfg_addr = a; #1;
    d = cfg_rdata;
  endtask

  task automatic setup(input int ch, input logic dir, input logic [1:0] step,
                       input logic [7:0] per, input logic [7:0] bank,
                       input logic [15:0] ofs, input logic [15:0] cnt);
    logic [6:0] b;
    b = {1'b0, 3'(ch), 3'd0};
    wr(b | 7'd0, {5'd0, step, dir});
    wr(b | 7'd1, per);
    wr(b | 7'd2, ofs[7:0]);
    wr(b | 7'd3, ofs[15:8]);
    wr(b | 7'd4, bank);
    wr(b | 7'd5, cnt[7:0]);
    wr(b | 7'd6, cnt[15:8]);
  endtask

  task automatic run(input logic [7:0] mask);
    n_bytes = 0; data_err = 0;
    wr(7'h40, mask);
    chk("R3 halt after start", {31'd0, halt_o}, 32'd1);
    while (halt_o) @(negedge clk);
  endtask

  task automatic rd16(input int ch, input int lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd({1'b0, 3'(ch), 3'(lo)}, l);
    rd({1'b0, 3'(ch), 3'(lo + 1)}, h);
    v = {h, l};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  v8;
    logic [15:0] v16;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 halt", {31'd0, halt_o}, 32'd0);
    chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 7; r++) begin
        rd({1'b0, 3'(c), 3'(r)}, v8);
        chk("R1 reg zero", {24'd0, v8}, 32'd0);
      end
    end
    rd(7'h40, v8);
    chk("R1 start mask zero", {24'd0, v8}, 32'd0);

    // R2 readback
    setup(3, 1'b1, 2'b10, 8'h9A, 8'hC3, 16'hBEEF, 16'h1357);
    rd(7'h18, v8); chk("R2 ctl", {24'd0, v8}, 32'h5);
    rd(7'h19, v8); chk("R2 per", {24'd0, v8}, 32'h9A);
    rd16(3, 2, v16); chk("R2 offset", {16'd0, v16}, 32'hBEEF);
    rd(7'h1C, v8); chk("R2 bank", {24'd0, v8}, 32'hC3);
    rd16(3, 5, v16); chk("R2 count", {16'd0, v16}, 32'h1357);

    // R5 R6 memory to peripheral, increment
    setup(0, 1'b0, 2'b00, 8'h18, 8'h12, 16'h1234, 16'd5);
    run(8'h01);
    chk("R5 byte count", n_bytes, 5);
    chk("R5 data copied", data_err, 0);
    for (int k = 0; k < 5; k++) begin
      chk("R6 inc address", log_m[k], 32'h121234 + k);
      chk("R5 dir0 writes periph", {31'd0, log_tp[k]}, 32'd1);
      chk("R5 periph addr", {24'd0, log_p[k]}, 32'h18);
    end
    rd16(0, 2, v16); chk("R9 final offset", {16'd0, v16}, 32'h1239);
    rd16(0, 5, v16); chk("R9 count zero", {16'd0, v16}, 32'd0);
    rd(7'h40, v8); chk("R9 start clear", {24'd0, v8}, 32'd0);

    // R7 R6 decrement wrap, peripheral to memory
    setup(2, 1'b1, 2'b01, 8'h2B, 8'h40, 16'h0001, 16'd3);
    run(8'h04);
    chk("R7 dec count", n_bytes, 3);
    chk("R7 data copied", data_err, 0);
    chk("R7 dec a0", log_m[0], 32'h400001);
    chk("R7 dec a1", log_m[1], 32'h400000);
    chk("R7 dec wrap", log_m[2], 32'h40FFFF);
    chk("R5 dir1 writes memory", {31'd0, log_tp[0]}, 32'd0);
    rd16(2, 2, v16); chk("R9 dec offset", {16'd0, v16}, 32'hFFFE);

    // R6 fixed
    setup(4, 1'b0, 2'b11, 8'h44, 8'h21, 16'h5A5A, 16'd4);
    run(8'h10);
    chk("R6 fixed count", n_bytes, 4);
    for (int k = 0; k < 4; k++) chk("R6 fixed addr", log_m[k], 32'h215A5A);
    rd16(4, 2, v16); chk("R6 fixed offset", {16'd0, v16}, 32'h5A5A);

    // R7 increment wrap
    setup(5, 1'b0, 2'b00, 8'h50, 8'h07, 16'hFFFE, 16'd3);
    run(8'h20);
    chk("R7 inc a0", log_m[0], 32'h07FFFE);
    chk("R7 inc a1", log_m[1], 32'h07FFFF);
    chk("R7 inc wrap", log_m[2], 32'h070000);

    // R4 ordering
    setup(1, 1'b0, 2'b00, 8'h11, 8'h01, 16'h0100, 16'd2);
    setup(2, 1'b0, 2'b00, 8'h22, 8'h02, 16'h0200, 16'd2);
    setup(5, 1'b0, 2'b00, 8'h55, 8'h05, 16'h0500, 16'd2);
    setup(7, 1'b0, 2'b00, 8'h77, 8'h07, 16'h0700, 16'd2);
    run(8'hA6);
    chk("R4 total bytes", n_bytes, 8);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] e;
      e = (k < 2) ? 8'h11 : (k < 4) ? 8'h22 : (k < 6) ? 8'h55 : 8'h77;
      chk("R4 channel order", {24'd0, log_p[k]}, {24'd0, e});
    end
    rd(7'h40, v8); chk("R9 mask clear after group", {24'd0, v8}, 32'd0);

    // R10 blank gate
    vblank_i = 1'b0; fblank_i = 1'b0;
    setup(0, 1'b0, 2'b00, 8'h0F, 8'h33, 16'h0010, 16'd2);
    n_bytes = 0;
    wr(7'h40, 8'h01);
    repeat (20) @(negedge clk);
    chk("R10 no bytes outside blank", n_bytes, 0);
    chk("R10 halt held", {31'd0, halt_o}, 32'd1);
    fblank_i = 1'b1;
    while (halt_o) @(negedge clk);
    chk("R10 forced blank proceeds", n_bytes, 2);
    fblank_i = 1'b0; vblank_i = 1'b1;

    // R8 zero count
    setup(6, 1'b0, 2'b00, 8'h66, 8'h55, 16'h0000, 16'h0000);
    run(8'h40);
    chk("R8 65536 bytes", n_bytes, 65536);
    chk("R8 data copied", data_err, 0);
    chk("R8 last address", last_m, 32'h55FFFF);
    rd16(6, 2, v16); chk("R8 offset wrapped", {16'd0, v16}, 32'h0000);
    rd16(6, 5, v16); chk("R8 count zero", {16'd0, v16}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule